// File: doc/BRIEF.md
# Receive Frame Filter and Ring Packer

This block sits behind a receive deserializer and sees each incoming Ethernet frame as a stream of bytes. The stream carries a start marker on the first byte, an end marker on the last byte, and an error marker that travels with the end marker. The first six bytes are the destination address. The block compares them with a programmed station address and with group-address rules held in a small receive-control register. A frame that fails the filter is abandoned: its header is never written and the ring pointer does not move.

An accepted frame is stored in a ring of 256-byte pages in local buffer memory. The ring runs from a first page up to, but not including, a stop page. Payload bytes go out on a byte-wide memory write port as they arrive, starting four bytes into the current page. When the frame ends, four bookkeeping bytes are written into the first four addresses of the current page. These are a status byte, the page where the next frame will start, and the 16-bit received byte count, low byte first. The current-page register then takes the next-page value.

A boundary page marks buffer space that software has not yet freed. A write that would land in that page drops the frame and raises a sticky overflow flag. The current page is left as it was.

Top module: `rxp_top`

## Requirements
- R1: While reset is held and just after it is released, `mem_we` is 0, `cur_page` is 0 and `ovf_flag` is 0.
- R2: A frame whose six destination bytes equal the station address (config addresses 0 to 5, byte 0 arriving first) is accepted whatever the receive-control bits are. Its status byte is 0x01.
- R3: A broadcast frame (all six destination bytes 0xFF) is accepted only when receive-control bit 0 is 1. Its status byte is 0x07. The multicast enable has no effect on broadcast frames.
- R4: A multicast frame (bit 0 of the first destination byte is 1, but the frame is not broadcast) is accepted only when receive-control bit 1 is 1. Its status byte is 0x03.
- R5: A frame that no enabled rule accepts gets no write at its header address, and `cur_page` is unchanged.
- R6: Frame byte i is written at address cur_page*256+4+i. An address that reaches stop_page*256 wraps to first_page*256.
- R7: Once the last byte has been written, four bytes are written at cur_page*256, in this order: status, next page, count low, count high. The count is the number of frame bytes received. Status bits: bit 0 received OK, bit 1 group address, bit 2 broadcast, bit 3 error.
- R8: The next page is the page that follows the last payload byte, rounded up to a whole page, with stop_page wrapping to first_page. `cur_page` takes this value in the cycle after the fourth header byte.
- R9: A frame whose end byte carries the error marker is dropped, unless receive-control bit 2 is 1. In that case it is stored with status bit 0 clear and bit 3 set.
- R10: A frame that ends within its first six bytes is dropped.
- R11: A write that would fall in the boundary page drops the frame. This holds for the end byte as well. `ovf_flag` goes to 1 and `cur_page` is unchanged. A write to the boundary register clears `ovf_flag`.
- R12: A start marker in the middle of a frame abandons that frame and starts a new one at the same page. Bytes that arrive while the header is being written are ignored, including a start marker.
- R13: Config addresses: 0 to 5 station bytes, 6 receive control, 7 first page, 8 stop page, 9 boundary page, 10 current page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 4 | Config register address |
| cfg_wdata | input | 8 | Config write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_err | input | 1 | Frame error, qualified by rx_eof |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 12 | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory write data |
| cur_page | output | 4 | Current receive page |
| ovf_flag | output | 1 | Sticky ring overflow flag |

## Verification
The two events that can land in the same cycle are the end of a frame and the boundary-page check on its final byte. In that cycle, committing the header and dropping the frame for overflow compete. The bench sends a 253-byte frame from the page just below the boundary, so the end byte is the first byte of the boundary page. It requires the overflow flag to rise, no header write and an unchanged current page. A 252-byte frame from the same page must instead commit, with the next page equal to the boundary. A second pairing places a new start marker in the first header-write cycle and requires it to be ignored.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEST,
        S_BODY,
        S_DROP,
        S_HDR
    } rxp_state_e;

    localparam int DA_BYTES = 6;

    localparam logic [3:0] CA_RCR   = 4'd6;
    localparam logic [3:0] CA_FIRST = 4'd7;
    localparam logic [3:0] CA_STOP  = 4'd8;
    localparam logic [3:0] CA_BND   = 4'd9;
    localparam logic [3:0] CA_CUR   = 4'd10;

    localparam int ST_OK  = 0;
    localparam int ST_GRP = 1;
    localparam int ST_BC  = 2;
    localparam int ST_ERR = 3;

    localparam int RC_BC  = 0;
    localparam int RC_MC  = 1;
    localparam int RC_BAD = 2;

endpackage

// File: rtl/rxp_cfg.sv
module rxp_cfg
    import rxp_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [3:0]                  cfg_addr,
    input  logic [7:0]                  cfg_wdata,
    input  logic                        cp_load,
    input  logic [PAGE_W-1:0]           cp_value,
    input  logic                        ovf_set,
    output logic [DA_BYTES-1:0][7:0]    sta,
    output logic [2:0]                  rcr,
    output logic [PAGE_W-1:0]           pg_first,
    output logic [PAGE_W-1:0]           pg_stop,
    output logic [PAGE_W-1:0]           pg_bnd,
    output logic [PAGE_W-1:0]           cur_page,
    output logic                        ovf
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta      <= '0;
            rcr      <= '0;
            pg_first <= '0;
            pg_stop  <= '0;
            pg_bnd   <= '0;
            cur_page <= '0;
            ovf      <= 1'b0;
        end else begin
            if (cfg_we) begin
                for (int k = 0; k < DA_BYTES; k++) begin
                    if (cfg_addr == 4'(k)) sta[k] <= cfg_wdata;
                end
                case (cfg_addr)
                    CA_RCR:   rcr      <= cfg_wdata[2:0];
                    CA_FIRST: pg_first <= cfg_wdata[PAGE_W-1:0];
                    CA_STOP:  pg_stop  <= cfg_wdata[PAGE_W-1:0];
                    CA_BND:   pg_bnd   <= cfg_wdata[PAGE_W-1:0];
                    default:  ;
                endcase
            end
            // a frame commit takes precedence over a software write
            if (cp_load)
                cur_page <= cp_value;
            else if (cfg_we && cfg_addr == CA_CUR)
                cur_page <= cfg_wdata[PAGE_W-1:0];
            if (ovf_set)
                ovf <= 1'b1;
            else if (cfg_we && cfg_addr == CA_BND)
                ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/rxp_dafilt.sv
module rxp_dafilt
    import rxp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic                     first,
    input  logic [2:0]               idx,
    input  logic [7:0]               data,
    input  logic [DA_BYTES-1:0][7:0] sta,
    input  logic [2:0]               rcr,
    output logic                     accept,
    output logic                     grp,
    output logic                     bc
);

    logic       phys_r, bc_r, grp_r, phys_n;
    logic [7:0] want;

    // running verdict including the byte now on the input
    always_comb begin
        want = '0;
        for (int k = 0; k < DA_BYTES; k++) begin
            if (idx == 3'(k)) want = sta[k];
        end
        phys_n = (first || phys_r) && (data == want);
        bc     = (first || bc_r) && (data == 8'hFF);
        grp    = first ? data[0] : grp_r;
        if (bc)
            accept = rcr[RC_BC];
        else if (grp)
            accept = rcr[RC_MC];
        else
            accept = phys_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_r <= 1'b0;
            bc_r   <= 1'b0;
            grp_r  <= 1'b0;
        end else if (step) begin
            phys_r <= phys_n;
            bc_r   <= bc;
            grp_r  <= grp;
        end
    end

endmodule

// File: rtl/rxp_ring.sv
module rxp_ring #(
    parameter int PAGE_W = 4,
    localparam int ADDR_W = PAGE_W + 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] pg_first,
    input  logic [PAGE_W-1:0] pg_stop,
    output logic [ADDR_W-1:0] addr_inc,
    output logic [PAGE_W-1:0] pg_after
);

    logic [ADDR_W-1:0] raw;
    logic [PAGE_W-1:0] pg;

    always_comb begin
        raw = addr + ADDR_W'(1);
        if (raw[ADDR_W-1:8] == pg_stop)
            addr_inc = {pg_first, 8'h00};
        else
            addr_inc = raw;
        // round the next free address up to a whole page
        pg = addr_inc[ADDR_W-1:8] + ((addr_inc[7:0] != 8'h00) ? PAGE_W'(1) : PAGE_W'(0));
        pg_after = (pg == pg_stop) ? pg_first : pg;
    end

endmodule

// File: rtl/rxp_top.sv
module rxp_top
    import rxp_pkg::*;
#(
    parameter int PAGE_W = 4,
    localparam int ADDR_W = PAGE_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_err,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [PAGE_W-1:0] cur_page,
    output logic              ovf_flag
);

    localparam logic [2:0] LAST_DA = 3'(DA_BYTES - 1);

    rxp_state_e state, state_nx;

    logic [DA_BYTES-1:0][7:0] sta;
    logic [2:0]               rcr;
    logic [PAGE_W-1:0]        pg_first, pg_stop, pg_bnd, nxt_pg, wa_pg_after;
    logic [ADDR_W-1:0]        wr_addr, base_addr, wa, wa_inc;
    logic [2:0]               didx, fidx;
    logic [1:0]               hidx;
    logic [15:0]              len;
    logic [7:0]               stat, hdr_byte;
    logic start, writing, hit, wr_ok, step, in_hdr, cp_load, drop_bad;
    logic accept, grp_n, bc_n, grp_r, bc_r;

    rxp_cfg #(.PAGE_W(PAGE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cp_load  (cp_load),
        .cp_value (nxt_pg),
        .ovf_set  (hit),
        .sta      (sta),
        .rcr      (rcr),
        .pg_first (pg_first),
        .pg_stop  (pg_stop),
        .pg_bnd   (pg_bnd),
        .cur_page (cur_page),
        .ovf      (ovf_flag)
    );

    rxp_dafilt u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .first (start),
        .idx   (fidx),
        .data  (rx_data),
        .sta   (sta),
        .rcr   (rcr),
        .accept(accept),
        .grp   (grp_n),
        .bc    (bc_n)
    );

    rxp_ring #(.PAGE_W(PAGE_W)) u_ring (
        .addr    (wa),
        .pg_first(pg_first),
        .pg_stop (pg_stop),
        .addr_inc(wa_inc),
        .pg_after(wa_pg_after)
    );

    // write-path control shared by next-state and outputs
    always_comb begin
        base_addr = {cur_page, 8'h00};
        in_hdr    = (state == S_HDR);
        start     = rx_valid && rx_sof && !in_hdr;
        writing   = start || (rx_valid && (state == S_DEST || state == S_BODY));
        wa        = start ? (base_addr + ADDR_W'(4)) : wr_addr;
        hit       = writing && (wa[ADDR_W-1:8] == pg_bnd);
        wr_ok     = writing && !hit;
        step      = wr_ok && (start || state == S_DEST);
        fidx      = start ? 3'd0 : didx;
        cp_load   = in_hdr && (hidx == 2'd3);
        drop_bad  = rx_err && !rcr[RC_BAD];
    end

    // next state
    always_comb begin
        state_nx = state;
        if (start) begin
            if (rx_eof)
                state_nx = S_IDLE;
            else if (hit)
                state_nx = S_DROP;
            else
                state_nx = S_DEST;
        end else begin
            unique case (state)
                S_IDLE: state_nx = S_IDLE;
                S_DEST: begin
                    if (rx_valid) begin
                        if (rx_eof)
                            state_nx = S_IDLE;
                        else if (hit)
                            state_nx = S_DROP;
                        else if (didx == LAST_DA)
                            state_nx = accept ? S_BODY : S_DROP;
                    end
                end
                S_BODY: begin
                    if (rx_valid) begin
                        if (hit)
                            state_nx = rx_eof ? S_IDLE : S_DROP;
                        else if (rx_eof)
                            state_nx = drop_bad ? S_IDLE : S_HDR;
                    end
                end
                S_DROP: begin
                    if (rx_valid && rx_eof) state_nx = S_IDLE;
                end
                S_HDR: begin
                    if (hidx == 2'd3) state_nx = S_IDLE;
                end
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // state register and frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            wr_addr <= '0;
            didx    <= '0;
            hidx    <= '0;
            len     <= '0;
            stat    <= '0;
            nxt_pg  <= '0;
            grp_r   <= 1'b0;
            bc_r    <= 1'b0;
        end else begin
            state <= state_nx;
            if (wr_ok) wr_addr <= wa_inc;
            if (start) begin
                didx <= 3'd1;
                len  <= 16'd1;
            end else if (writing) begin
                len <= len + 16'd1;
                if (state == S_DEST) didx <= didx + 3'd1;
            end
            if (state == S_DEST && step && didx == LAST_DA) begin
                grp_r <= grp_n;
                bc_r  <= bc_n;
            end
            if (state == S_BODY && wr_ok && rx_eof) begin
                stat         <= 8'h00;
                stat[ST_OK]  <= !rx_err;
                stat[ST_GRP] <= grp_r;
                stat[ST_BC]  <= bc_r;
                stat[ST_ERR] <= rx_err;
                nxt_pg       <= wa_pg_after;
            end
            hidx <= in_hdr ? hidx + 2'd1 : 2'd0;
        end
    end

    // outputs
    always_comb begin
        unique case (hidx)
            2'd0: hdr_byte = stat;
            2'd1: hdr_byte = 8'(nxt_pg);
            2'd2: hdr_byte = len[7:0];
            2'd3: hdr_byte = len[15:8];
            default: hdr_byte = stat;
        endcase
        mem_we    = wr_ok || in_hdr;
        mem_addr  = in_hdr ? (base_addr + ADDR_W'(hidx)) : wa;
        mem_wdata = in_hdr ? hdr_byte : rx_data;
    end

endmodule

// File: rtl/rxp_chk.sv
module rxp_chk #(
    parameter int PAGE_W = 4,
    localparam int ADDR_W = PAGE_W + 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [PAGE_W-1:0] pg_first,
    input logic [PAGE_W-1:0] pg_stop,
    input logic [PAGE_W-1:0] pg_bnd,
    input logic [PAGE_W-1:0] cur_page,
    input logic              ovf,
    input logic              in_hdr,
    input logic [1:0]        hidx,
    input logic              cfg_we,
    input logic [3:0]        cfg_addr
);

    // R11: nothing is ever written into the boundary page
    a_r11_no_bnd_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:8] != pg_bnd));

    // R6: with a sane ring and current page, writes stay in the ring
    a_r6_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && pg_first < pg_stop && cur_page >= pg_first && cur_page < pg_stop)
        |-> (mem_addr[ADDR_W-1:8] >= pg_first && mem_addr[ADDR_W-1:8] < pg_stop));

    // R7: header bytes go out in four back-to-back cycles
    a_r7_hdr_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hdr && hidx != 2'd3) |=> (in_hdr && mem_we));

    // R8: the page register moves only on a header finish or a software write
    a_r8_cp_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_page != $past(cur_page)) && !$past(cfg_we && cfg_addr == 4'd10))
        |-> $past(in_hdr && hidx == 2'd3));

    // R11: overflow never coincides with a page advance
    a_r11_ovf_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf) && !$past(cfg_we)) |-> $stable(cur_page));

endmodule

bind rxp_top rxp_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .pg_first(pg_first),
    .pg_stop (pg_stop),
    .pg_bnd  (pg_bnd),
    .cur_page(cur_page),
    .ovf     (ovf_flag),
    .in_hdr  (in_hdr),
    .hidx    (hidx),
    .cfg_we  (cfg_we),
    .cfg_addr(cfg_addr)
);

// File: tb/rxp_top_tb.sv
module rxp_top_tb;

    localparam int AW = 12;
    localparam int RF = 2;
    localparam int RS = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          cfg_we;
    logic [3:0]    cfg_addr;
    logic [7:0]    cfg_wdata;
    logic          rx_valid, rx_sof, rx_eof, rx_err;
    logic [7:0]    rx_data;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [3:0]    cur_page;
    logic          ovf_flag;

    rxp_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_page(cur_page),
        .ovf_flag(ovf_flag)
    );

    logic [7:0] mem [0:(1<<AW)-1];
    int hits = 0;
    int watch = -1;

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (int'(mem_addr) == watch) hits <= hits + 1;
        end
    end

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    // fields: dtype[26:25] err[24] rcr[23:21] acc[20] stat[19:12] len[11:0]
    // dtype 0 station, 1 broadcast, 2 multicast, 3 other unicast
    localparam logic [26:0] VEC [12] = '{
        {2'd0, 1'b0, 3'd3, 1'b1, 8'h01, 12'd60},   // R2
        {2'd1, 1'b0, 3'd1, 1'b1, 8'h07, 12'd64},   // R3
        {2'd1, 1'b0, 3'd2, 1'b0, 8'h00, 12'd64},   // R3 refused
        {2'd2, 1'b0, 3'd2, 1'b1, 8'h03, 12'd70},   // R4
        {2'd2, 1'b0, 3'd1, 1'b0, 8'h00, 12'd70},   // R4 refused
        {2'd3, 1'b0, 3'd7, 1'b0, 8'h00, 12'd80},   // R5
        {2'd0, 1'b0, 3'd0, 1'b1, 8'h01, 12'd300},  // R2 two pages
        {2'd0, 1'b1, 3'd0, 1'b0, 8'h00, 12'd50},   // R9 dropped
        {2'd0, 1'b1, 3'd4, 1'b1, 8'h08, 12'd50},   // R9 kept, next page wraps
        {2'd0, 1'b0, 3'd0, 1'b1, 8'h01, 12'd520},  // R2 three pages
        {2'd1, 1'b1, 3'd5, 1'b1, 8'h0E, 12'd400},  // R9 broadcast kept
        {2'd0, 1'b0, 3'd0, 1'b1, 8'h01, 12'd300}   // R6 data wraps
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic int fbyte(input int dt, input int i, input int seed);
        if (i < 6) begin
            case (dt)
                0: case (i) 0: return 8'h02; 1: return 8'h11; 2: return 8'h22;
                            3: return 8'h33; 4: return 8'h44; default: return 8'h55; endcase
                1: return 8'hFF;
                2: case (i) 0: return 8'h01; 1: return 8'h00; 2: return 8'h5E;
                            3: return 8'h00; 4: return 8'h00; default: return 8'h07; endcase
                default: case (i) 0: return 8'h02; 1: return 8'h11; 2: return 8'h22;
                            3: return 8'h33; 4: return 8'h44; default: return 8'h56; endcase
            endcase
        end
        return (seed + i * 7) & 255;
    endfunction

    function automatic int ring_a(input int cp, input int i);
        int lin = cp * 256 + 4 + i;
        if (lin >= RS * 256) lin -= (RS - RF) * 256;
        return lin;
    endfunction

    function automatic int exp_next(input int cp, input int len);
        int n = cp + (4 + len + 255) / 256;
        if (n >= RS) n -= (RS - RF);
        return n;
    endfunction

    task automatic cfg_wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic send(input int dt, input int len, input bit err, input bit eof_on, input int seed);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = 8'(fbyte(dt, i, seed));
            rx_sof   = (i == 0);
            rx_eof   = eof_on && (i == len - 1);
            rx_err   = eof_on && (i == len - 1) && err;
            @(posedge clk); #1;
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic verify_acc(input string req, input int dt, input int len,
                              input int seed, input int cp, input int st);
        int base = cp * 256;
        int nx = exp_next(cp, len);
        int bad = 0;
        chk(req, "status byte", int'(mem[base]), st);
        chk("R8", "next page byte", int'(mem[base + 1]), nx);
        chk("R7", "count low", int'(mem[base + 2]), len & 255);
        chk("R7", "count high", int'(mem[base + 3]), len >> 8);
        for (int i = 0; i < len; i++) begin
            if (mem[ring_a(cp, i)] !== 8'(fbyte(dt, i, seed))) bad++;
        end
        chk("R6", "payload mismatches", bad, 0);
        chk("R8", "cur_page", int'(cur_page), nx);
    endtask

    task automatic verify_rej(input string req, input int cp, input int h0);
        chk(req, "header writes", hits - h0, 0);
        chk(req, "cur_page", int'(cur_page), cp);
    endtask

    initial begin
        int cp;
        int h0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        rx_valid = 1'b0; rx_data = '0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "mem_we in reset", int'(mem_we), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "cur_page", int'(cur_page), 0);
        chk("R1", "ovf_flag", int'(ovf_flag), 0);

        // R13 register map
        cfg_wr(0, 8'h02); cfg_wr(1, 8'h11); cfg_wr(2, 8'h22);
        cfg_wr(3, 8'h33); cfg_wr(4, 8'h44); cfg_wr(5, 8'h55);
        cfg_wr(7, RF); cfg_wr(8, RS); cfg_wr(9, 0); cfg_wr(10, RF);
        chk("R13", "cur_page write", int'(cur_page), RF);
        cp = RF;

        for (int r = 0; r < 12; r++) begin
            logic [26:0] v = VEC[r];
            int dt = int'(v[26:25]);
            int len = int'(v[11:0]);
            int seed = r * 13 + 5;
            string req;
            if (dt == 1) req = "R3";
            else if (dt == 2) req = "R4";
            else if (dt == 3) req = "R5";
            else if (v[24]) req = "R9";
            else req = "R2";
            cfg_wr(6, int'(v[23:21]));
            watch = cp * 256;
            settle();
            h0 = hits;
            send(dt, len, v[24], 1'b1, seed);
            settle();
            if (v[20]) begin
                verify_acc(req, dt, len, seed, cp, int'(v[19:12]));
                cp = exp_next(cp, len);
            end else begin
                verify_rej(req, cp, h0);
            end
        end

        // R10: runt frame
        cfg_wr(6, 3);
        watch = cp * 256; settle(); h0 = hits;
        send(0, 5, 1'b0, 1'b1, 1);
        settle();
        verify_rej("R10", cp, h0);

        // R12: start marker mid-frame restarts at the same page
        send(0, 20, 1'b0, 1'b0, 9);
        send(0, 40, 1'b0, 1'b1, 77);
        settle();
        verify_acc("R12", 0, 40, 77, cp, 8'h01);
        cp = exp_next(cp, 40);

        // R12: a new frame during header writes is ignored
        watch = exp_next(cp, 30) * 256; settle(); h0 = hits;
        send(0, 30, 1'b0, 1'b1, 21);
        send(0, 30, 1'b0, 1'b1, 55);
        settle();
        verify_acc("R12", 0, 30, 21, cp, 8'h01);
        chk("R12", "second frame header writes", hits - h0, 0);
        cp = exp_next(cp, 30);

        // R11: overflow on the very last byte
        cfg_wr(9, cp + 1);
        watch = cp * 256; settle(); h0 = hits;
        send(0, 253, 1'b0, 1'b1, 3);
        settle();
        chk("R11", "ovf_flag on end byte", int'(ovf_flag), 1);
        verify_rej("R11", cp, h0);
        cfg_wr(9, cp + 1);
        chk("R11", "ovf_flag cleared", int'(ovf_flag), 0);

        // R11: exact fit just below the boundary is accepted
        send(0, 252, 1'b0, 1'b1, 4);
        settle();
        verify_acc("R11", 0, 252, 4, cp, 8'h01);
        chk("R11", "ovf_flag after fit", int'(ovf_flag), 0);
        cp = exp_next(cp, 252);

        // R11: overflow mid-frame
        cfg_wr(9, cp + 1);
        watch = cp * 256; settle(); h0 = hits;
        send(0, 400, 1'b0, 1'b1, 6);
        settle();
        chk("R11", "ovf_flag mid-frame", int'(ovf_flag), 1);
        verify_rej("R11", cp, h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R12 watchdog act=0 exp=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule